// File: doc/BRIEF.md
# BCD Calendar Clock

This block keeps the time of day and the calendar date in packed BCD registers. A fast reference tick enters a prescaler. Every `TICKS_PER_SEC` ticks the prescaler advances the seconds by one. Carries then ripple through minutes, hours, day of month, month and a two-digit year. A century flag stored with the month flips whenever the year wraps from 99 to 00. The hours counter runs in one of two formats: 24-hour, or 12-hour with a PM flag. A control bit selects the format. A weekday counter steps at every midnight.

Software loads any field through a single write port, addressed by a 4-bit register number. Every field is always visible on its own registered output. Two sticky status flags record events from outside the block: the oscillator stopped, or the supply voltage fell. Each flag stays set until software clears it.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset the block reads 00:00:00 in 24-hour mode, weekday 0, day 01, month 01, year 00, with the century flag and both status flags clear.
- R2: Seconds advance once per `TICKS_PER_SEC` input ticks. A write to the seconds register clears the prescaler, so the next advance comes exactly `TICKS_PER_SEC` ticks later.
- R3: Seconds and minutes count in BCD (09 is followed by 10). Each rolls from 59 to 00 and carries into the next field.
- R4: In 24-hour mode, hours run 00 to 23. At the step from 23:59:59 the hours become 00 and the date advances.
- R5: In 12-hour mode, hours bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. 11 AM becomes 12 PM and 12 becomes 01 with the flag kept. 11 PM becomes 12 AM, and this step advances the date.
- R6: Day of month rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other non-February months, advancing the month.
- R7: February ends at 29 when the BCD year is divisible by 4 (00 included), otherwise at 28.
- R8: Month 12 rolls to 01 and increments the year. Year 99 rolls to 00 and toggles the century flag (month register bit 7). Other year steps leave the flag alone.
- R9: Weekday increments at every date advance and wraps from 6 to 0.
- R10: Register map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month (bit 7 century), 6 year, 14 control, 15 status. A write loads its field, and in a cycle with a write no counter advances, even on the tick that would end a second.
- R11: Status register bit 4 (oscillator stop) and bit 6 (low voltage) are set by a high level on their inputs and hold. Writing 0 to a bit clears it; writing 1 to it has no effect.
- R12: Control register bit 5 selects 24-hour mode when 1 and 12-hour mode when 0. Changing it does not recode the stored hours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Sub-second reference tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number |
| wr_data | input | 8 | Write data |
| osc_stop_in | input | 1 | Oscillator-stop event from the analog side |
| low_volt_in | input | 1 | Low-supply event from the analog side |
| sec_q | output | 7 | Seconds, BCD |
| min_q | output | 7 | Minutes, BCD |
| hour_q | output | 6 | Hours, BCD (bit 5 PM in 12-hour mode) |
| wday_q | output | 3 | Weekday 0..6 |
| mday_q | output | 6 | Day of month, BCD |
| month_q | output | 5 | Month, BCD 01..12 |
| century_q | output | 1 | Century flag |
| year_q | output | 8 | Year, BCD 00..99 |
| mode24_q | output | 1 | 24-hour mode selected |
| osc_stop_q | output | 1 | Sticky oscillator-stop flag |
| low_volt_q | output | 1 | Sticky low-voltage flag |

## Verification
The bench builds the block with `TICKS_PER_SEC` set to 3. A second then costs three ticks, and every rollover can be reached by loading the registers one second before it. That small divisor also makes it cheap to place a register write on exactly the tick that completes a second, and to restart the prescaler part-way through a second. Month ends, leap and non-leap Februaries, the year 99 wrap in both century states, and both hour formats are each set up directly through the write port.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [3:0] A_SEC  = 4'd0;
  localparam logic [3:0] A_MIN  = 4'd1;
  localparam logic [3:0] A_HOUR = 4'd2;
  localparam logic [3:0] A_WDAY = 4'd3;
  localparam logic [3:0] A_MDAY = 4'd4;
  localparam logic [3:0] A_MON  = 4'd5;
  localparam logic [3:0] A_YEAR = 4'd6;
  localparam logic [3:0] A_CTL  = 4'd14;
  localparam logic [3:0] A_STAT = 4'd15;

  // plain BCD +1 on a two-digit value; callers handle their own wrap
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // final day of a month (BCD month, BCD result)
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  input  logic clr,
  input  logic hold,
  output logic step_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign step_o = tick_in && (cnt == LAST) && !hold;

  // R2: a step only ever follows a full count of ticks
  p_step_at_end_r2: assert property (@(posedge clk) disable iff (rst)
    step_o |=> (cnt == '0));
endmodule

// File: rtl/cal_time.sv
module cal_time
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [6:0] wr_data,
  input  logic       mode24,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic       day_step
);
  logic       min_step, hr_step, midnight;
  logic [6:0] sec_nx, min_nx;
  logic [5:0] hour_nx;

  assign min_step = step && (sec_q == 7'h59);
  assign hr_step  = min_step && (min_q == 7'h59);
  assign midnight = mode24 ? (hour_q == 6'h23) : (hour_q == 6'h31);
  assign day_step = hr_step && midnight;

  always_comb begin
    sec_nx = (sec_q == 7'h59) ? 7'h00 : 7'(bcd_inc({1'b0, sec_q}));
    min_nx = (min_q == 7'h59) ? 7'h00 : 7'(bcd_inc({1'b0, min_q}));
    if (mode24)
      hour_nx = (hour_q == 6'h23) ? 6'h00 : 6'(bcd_inc({2'b0, hour_q}));
    else if (hour_q[4:0] == 5'h11)
      hour_nx = {~hour_q[5], 5'h12};
    else if (hour_q[4:0] == 5'h12)
      hour_nx = {hour_q[5], 5'h01};
    else
      hour_nx = {hour_q[5], 5'(bcd_inc({3'b0, hour_q[4:0]}))};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_SEC:   sec_q  <= wr_data;
        A_MIN:   min_q  <= wr_data;
        A_HOUR:  hour_q <= wr_data[5:0];
        default: ;
      endcase
    end else begin
      if (step)     sec_q  <= sec_nx;
      if (min_step) min_q  <= min_nx;
      if (hr_step)  hour_q <= hour_nx;
    end
  end

  // R2: seconds hold without a step or write
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_en) |=> $stable(sec_q));
  // R3: seconds wrap at 59
  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && sec_q == 7'h59) |=> (sec_q == 7'h00));
  // R4: 24-hour midnight wrap
  p_hour24_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (hr_step && !wr_en && mode24 && hour_q == 6'h23) |=> (hour_q == 6'h00));
  // R10: a write loads the seconds field
  p_sec_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_SEC) |=> (sec_q == $past(wr_data)));
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_step,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [2:0] wday_q,
  output logic [5:0] mday_q,
  output logic [4:0] month_q,
  output logic       century_q,
  output logic [7:0] year_q
);
  logic leap, mon_step, yr_step;

  // BCD year mod 4 = (2*tens + ones) mod 4
  assign leap     = (2'({year_q[4], 1'b0}) + year_q[1:0]) == 2'b00;
  assign mon_step = day_step && (mday_q == last_day(month_q, leap));
  assign yr_step  = mon_step && (month_q == 5'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      wday_q    <= '0;
      mday_q    <= 6'h01;
      month_q   <= 5'h01;
      century_q <= 1'b0;
      year_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_WDAY: wday_q <= wr_data[2:0];
        A_MDAY: mday_q <= wr_data[5:0];
        A_MON: begin
          month_q   <= wr_data[4:0];
          century_q <= wr_data[7];
        end
        A_YEAR:  year_q <= wr_data;
        default: ;
      endcase
    end else begin
      if (day_step) begin
        wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;
        mday_q <= mon_step ? 6'h01 : 6'(bcd_inc({2'b0, mday_q}));
      end
      if (mon_step)
        month_q <= yr_step ? 5'h01 : 5'(bcd_inc({3'b0, month_q}));
      if (yr_step) begin
        year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        if (year_q == 8'h99) century_q <= ~century_q;
      end
    end
  end

  // R8: century toggles on the 99 -> 00 wrap
  p_century_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (yr_step && !wr_en && year_q == 8'h99) |=> (century_q != $past(century_q)));
  // R9: weekday stays in range after a date step
  p_wday_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (day_step && !wr_en && wday_q == 3'd6) |=> (wday_q == 3'd0));
endmodule

// File: rtl/cal_status.sv
module cal_status
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [2:0] wr_data,   // bits 6:4 of the written byte
  input  logic       osc_stop_in,
  input  logic       low_volt_in,
  output logic       mode24_q,
  output logic       osc_stop_q,
  output logic       low_volt_q
);
  logic wr_ctl, wr_stat;
  assign wr_ctl  = wr_en && (wr_addr == A_CTL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode24_q   <= 1'b1;
      osc_stop_q <= 1'b0;
      low_volt_q <= 1'b0;
    end else begin
      if (wr_ctl) mode24_q <= wr_data[1];
      osc_stop_q <= (osc_stop_q && !(wr_stat && !wr_data[0])) || osc_stop_in;
      low_volt_q <= (low_volt_q && !(wr_stat && !wr_data[2])) || low_volt_in;
    end
  end

  // R11: flags hold unless cleared by a status write
  p_osc_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (osc_stop_q && !wr_stat) |=> osc_stop_q);
  p_lowv_set_r11: assert property (@(posedge clk) disable iff (rst)
    low_volt_in |=> low_volt_q);
  // R12: control write selects the hour format
  p_mode_load_r12: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (mode24_q == $past(wr_data[1])));
endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       osc_stop_in,
  input  logic       low_volt_in,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic [2:0] wday_q,
  output logic [5:0] mday_q,
  output logic [4:0] month_q,
  output logic       century_q,
  output logic [7:0] year_q,
  output logic       mode24_q,
  output logic       osc_stop_q,
  output logic       low_volt_q
);
  logic step, day_step;

  cal_prescaler #(.DIV(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst(rst), .tick_in(tick_in),
    .clr(wr_en && (wr_addr == A_SEC)), .hold(wr_en), .step_o(step)
  );

  cal_time u_time (
    .clk(clk), .rst(rst), .step(step), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data[6:0]), .mode24(mode24_q),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_step(day_step)
  );

  cal_date u_date (
    .clk(clk), .rst(rst), .day_step(day_step), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .wday_q(wday_q), .mday_q(mday_q), .month_q(month_q),
    .century_q(century_q), .year_q(year_q)
  );

  cal_status u_stat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data[6:4]), .osc_stop_in(osc_stop_in), .low_volt_in(low_volt_in),
    .mode24_q(mode24_q), .osc_stop_q(osc_stop_q), .low_volt_q(low_volt_q)
  );

  // R1: reset lands on the documented start state
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (sec_q == 7'h00 && mday_q == 6'h01 && month_q == 5'h01 && mode24_q));
endmodule

// File: tb/sim_bcd_cal_clock.sv
`timescale 1ns/1ps
module sim_bcd_cal_clock;
  localparam int DIV = 3;

  logic clk = 0, rst = 1, tick_in = 0, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic osc_stop_in = 0, low_volt_in = 0;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q, mday_q;
  logic [2:0] wday_q;
  logic [4:0] month_q;
  logic [7:0] year_q;
  logic century_q, mode24_q, osc_stop_q, low_volt_q;

  always #2.5 clk = ~clk;

  bcd_cal_clock #(.TICKS_PER_SEC(DIV)) u0 (.*);

  typedef enum int {F_SEC, F_MIN, F_HOUR, F_WDAY, F_MDAY, F_MON, F_YEAR,
                    F_CENT, F_MODE, F_OSC, F_LOWV} fld_t;
  typedef struct { string req; fld_t f; logic [7:0] v; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] actual(fld_t f);
    case (f)
      F_SEC:  return {1'b0, sec_q};
      F_MIN:  return {1'b0, min_q};
      F_HOUR: return {2'b0, hour_q};
      F_WDAY: return {5'b0, wday_q};
      F_MDAY: return {2'b0, mday_q};
      F_MON:  return {3'b0, month_q};
      F_YEAR: return year_q;
      F_CENT: return {7'b0, century_q};
      F_MODE: return {7'b0, mode24_q};
      F_OSC:  return {7'b0, osc_stop_q};
      default: return {7'b0, low_volt_q};
    endcase
  endfunction

  // monitor: compares queued expectations while inputs are idle
  initial forever begin
    @(posedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (actual(it.f) !== it.v) begin
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", it.req, it.f.name(), actual(it.f), it.v);
      end
    end
  end

  task automatic expect_f(string req, fld_t f, logic [7:0] v);
    item_t it;
    it.req = req; it.f = f; it.v = v;
    q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1;
      @(negedge clk); tick_in = 0;
    end
  endtask

  task automatic one_sec(); ticks(DIV); endtask

  task automatic set_all(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [7:0] wd,
                         logic [7:0] md, logic [7:0] mo, logic [7:0] yr);
    wr(4'd2, h); wr(4'd1, m); wr(4'd3, wd); wr(4'd4, md);
    wr(4'd5, mo); wr(4'd6, yr); wr(4'd0, s);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    expect_f("R1", F_SEC, 8'h00); expect_f("R1", F_MIN, 8'h00); expect_f("R1", F_HOUR, 8'h00);
    expect_f("R1", F_WDAY, 8'h00); expect_f("R1", F_MDAY, 8'h01); expect_f("R1", F_MON, 8'h01);
    expect_f("R1", F_YEAR, 8'h00); expect_f("R1", F_CENT, 8'h00); expect_f("R1", F_MODE, 8'h01);
    expect_f("R1", F_OSC, 8'h00); expect_f("R1", F_LOWV, 8'h00);

    // R2 prescaler
    wr(4'd0, 8'h10); ticks(DIV - 1); expect_f("R2", F_SEC, 8'h10);
    ticks(1); expect_f("R2", F_SEC, 8'h11);
    ticks(DIV - 1); wr(4'd0, 8'h20); ticks(DIV - 1); expect_f("R2", F_SEC, 8'h20);
    ticks(1); expect_f("R2", F_SEC, 8'h21);

    // R3 BCD and carries
    wr(4'd0, 8'h09); one_sec(); expect_f("R3", F_SEC, 8'h10);
    set_all(8'h05, 8'h59, 8'h59, 8'h01, 8'h10, 8'h03, 8'h24); one_sec();
    expect_f("R3", F_SEC, 8'h00); expect_f("R3", F_MIN, 8'h00); expect_f("R3", F_HOUR, 8'h06);
    expect_f("R3", F_MDAY, 8'h10);

    // R4 / R9 24-hour midnight
    set_all(8'h23, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03, 8'h24); one_sec();
    expect_f("R4", F_HOUR, 8'h00); expect_f("R4", F_MDAY, 8'h11); expect_f("R9", F_WDAY, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h06, 8'h10, 8'h03, 8'h24); one_sec();
    expect_f("R9", F_WDAY, 8'h00);
    set_all(8'h12, 8'h59, 8'h59, 8'h06, 8'h10, 8'h03, 8'h24); one_sec();
    expect_f("R12", F_HOUR, 8'h13); expect_f("R9", F_WDAY, 8'h06);

    // R5 / R12 12-hour mode
    wr(4'd14, 8'h00); expect_f("R12", F_MODE, 8'h00);
    set_all(8'h11, 8'h59, 8'h59, 8'h01, 8'h05, 8'h03, 8'h24); one_sec();
    expect_f("R5", F_HOUR, 8'h32); expect_f("R5", F_MDAY, 8'h05);
    set_all(8'h32, 8'h59, 8'h59, 8'h01, 8'h05, 8'h03, 8'h24); one_sec();
    expect_f("R5", F_HOUR, 8'h21);
    set_all(8'h31, 8'h59, 8'h59, 8'h01, 8'h05, 8'h03, 8'h24); one_sec();
    expect_f("R5", F_HOUR, 8'h12); expect_f("R5", F_MDAY, 8'h06); expect_f("R5", F_WDAY, 8'h02);
    set_all(8'h09, 8'h59, 8'h59, 8'h01, 8'h05, 8'h03, 8'h24); one_sec();
    expect_f("R12", F_HOUR, 8'h10);
    wr(4'd14, 8'h20); expect_f("R12", F_MODE, 8'h01); expect_f("R12", F_HOUR, 8'h10);

    // R6 30/31-day months
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h30, 8'h04, 8'h24); one_sec();
    expect_f("R6", F_MDAY, 8'h01); expect_f("R6", F_MON, 8'h05);
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h30, 8'h05, 8'h24); one_sec();
    expect_f("R6", F_MDAY, 8'h31); expect_f("R6", F_MON, 8'h05);

    // R7 February
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h24); one_sec();
    expect_f("R7", F_MDAY, 8'h29); expect_f("R7", F_MON, 8'h02);
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h29, 8'h02, 8'h24); one_sec();
    expect_f("R7", F_MDAY, 8'h01); expect_f("R7", F_MON, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h23); one_sec();
    expect_f("R7", F_MDAY, 8'h01); expect_f("R7", F_MON, 8'h03);
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h28, 8'h02, 8'h00); one_sec();
    expect_f("R7", F_MDAY, 8'h29);

    // R8 year and century
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h31, 8'h12, 8'h99); one_sec();
    expect_f("R8", F_MON, 8'h01); expect_f("R8", F_MDAY, 8'h01);
    expect_f("R8", F_YEAR, 8'h00); expect_f("R8", F_CENT, 8'h01);
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h31, 8'h12, 8'h19); one_sec();
    expect_f("R8", F_YEAR, 8'h20); expect_f("R8", F_CENT, 8'h00);
    set_all(8'h23, 8'h59, 8'h59, 8'h00, 8'h31, 8'h92, 8'h99); one_sec();
    expect_f("R8", F_YEAR, 8'h00); expect_f("R8", F_CENT, 8'h00);

    // R10 write wins over the completing tick
    wr(4'd0, 8'h30); ticks(DIV - 1);
    @(negedge clk); tick_in = 1; wr_en = 1; wr_addr = 4'd1; wr_data = 8'h42;
    @(negedge clk); tick_in = 0; wr_en = 0;
    expect_f("R10", F_SEC, 8'h30); expect_f("R10", F_MIN, 8'h42);
    one_sec(); expect_f("R10", F_SEC, 8'h31);

    // R11 sticky status flags
    @(negedge clk); osc_stop_in = 1; @(negedge clk); osc_stop_in = 0;
    repeat (3) @(negedge clk);
    expect_f("R11", F_OSC, 8'h01); expect_f("R11", F_LOWV, 8'h00);
    wr(4'd15, 8'h40); expect_f("R11", F_OSC, 8'h00); expect_f("R11", F_LOWV, 8'h00);
    @(negedge clk); low_volt_in = 1; @(negedge clk); low_volt_in = 0;
    expect_f("R11", F_LOWV, 8'h01);
    wr(4'd15, 8'h10); expect_f("R11", F_LOWV, 8'h00); expect_f("R11", F_OSC, 8'h00);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule